// File: doc/BRIEF.md
# Burst-Read Flash Interface

This block is the read side of a NOR-style flash. Its read timing comes from a 16-bit configuration word. A two-write command pair loads that word from the low address lines. After reset, the block answers plain asynchronous reads from a small computed array. Once the configuration selects synchronous mode, an address strobe starts a clocked burst. The configuration word sets:

- the first-access latency,
- the hold length of each data word,
- the WAIT pin's polarity and lead,
- the clock edge that drives the data,
- the burst ordering.

Bus strobes are sampled on the rising clock edge. A write is any cycle with `ce_n` and `we_n` both low. A burst starts on any cycle with `ce_n` and `adv_n` low and `we_n` high, while the block is in array mode with synchronous reads selected. The configuration word can be read back through the identifier space.

Top module: `flash_burst_rd`

## Requirements
- R1: After reset the configuration word is 16'hBFCF, the block is in array mode with asynchronous reads, `dvalid` is 0 and `wait_o` is 0 (inactive for the active-high default).
- R2: Two writes load the configuration word. The first carries command 8'h60 and the second carries command 8'h03. The new value is taken from `addr[15:0]` of the second write, and the block is then in array mode.
- R3: If the write that follows 8'h60 carries any code other than 8'h03, the configuration word is unchanged and the block returns to array mode.
- R4: Command 8'h90 enters identifier mode. In that mode a read at `addr[7:0]` = 8'h05 returns the configuration word and any other offset returns 0. Command 8'hFF returns to array mode.
- R5: In array mode with bit 15 = 1, `rdata` shows word(i) = {i ^ 8'hC3, i}, where i = `addr[7:0]`, without a clock, while `ce_n` and `oe_n` are low. Otherwise `rdata` is 0. Write codes that are not commands are ignored.
- R6: With bit 15 = 0, the first word of a burst is valid L clocks after the clock that samples the address. L is bits [13:11] when they are 2..5; any other code gives 5.
- R7: Bit 9 = 0 holds each burst word for one clock; bit 9 = 1 holds each word for two clocks.
- R8: WAIT is active from the clock after the address strobe until the first valid word. With bit 8 = 1 it ends one word-hold period earlier. The active level equals bit 10.
- R9: Bits [2:0] set the burst length: 1 = 4 words, 2 = 8 words, 3 = 16 words, anything else = continuous. With bit 3 = 0 and a finite length, addresses wrap inside the aligned block. Otherwise they advance linearly, modulo the array size.
- R10: Bit 6 = 1 updates burst outputs on the rising edge. Bit 6 = 0 updates them on the following falling edge.
- R11: A clock that samples `ce_n` high ends the burst: `dvalid` drops and WAIT goes inactive.
- R12: `dvalid` and an active WAIT never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable for asynchronous reads, active low |
| addr | input | 16 | Read address; configuration value during the setup writes |
| cmd | input | 8 | Command code on write cycles |
| rdata | output | 16 | Read data |
| dvalid | output | 1 | A burst word is on `rdata` |
| wait_o | output | 1 | WAIT pin, polarity set by the configuration |

## Verification
Two functions can meet in one cycle: the end of the WAIT window and the first valid data word. With bit 8 set, WAIT ends one hold period early. When that period covers the whole latency (two-clock hold at latency 2), WAIT never asserts. The bench drives random configurations across every latency, hold, lead and polarity setting. In each clock it compares `wait_o` and `dvalid` with windows computed from the configuration, and it flags any cycle in which both are active.

// File: rtl/flash_rd_pkg.sv
// Package: shared command codes, configuration bit positions, read modes
// and the computed array contents used by the burst-read flash interface.
package flash_rd_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_IDENT  = 2'd1,
        MODE_CFGSET = 2'd2
    } rd_mode_e;

    localparam logic [7:0]  CMD_CFG_SETUP   = 8'h60;
    localparam logic [7:0]  CMD_CFG_CONFIRM = 8'h03;
    localparam logic [7:0]  CMD_READ_ID     = 8'h90;
    localparam logic [7:0]  CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0]  ID_CFG_OFFSET   = 8'h05;
    localparam logic [15:0] CFG_RESET       = 16'hBFCF;

    localparam int CB_ASYNC   = 15;
    localparam int CB_LAT_HI  = 13;
    localparam int CB_LAT_LO  = 11;
    localparam int CB_WPOL    = 10;
    localparam int CB_HOLD2   = 9;
    localparam int CB_WLEAD   = 8;
    localparam int CB_RISE    = 6;
    localparam int CB_NOWRAP  = 3;
    localparam int CB_BL_HI   = 2;
    localparam int CB_BL_LO   = 0;

    // Array word for a given index: upper byte scrambled, lower byte plain.
    function automatic logic [15:0] array_word(input logic [15:0] idx);
        return {idx[7:0] ^ 8'hC3, idx[7:0]};
    endfunction

endpackage

// File: rtl/flash_cmd_ctrl.sv
// Command decoder: tracks the read mode and owns the configuration word.
// Assumes one write per cycle in which wr_stb is high; the value loaded is
// taken from the confirm write of the two-write setup pair.
module flash_cmd_ctrl
    import flash_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [7:0]       cmd,
    input  logic [15:0]      cfg_in,
    output logic [15:0]      cfg,
    output rd_mode_e         mode
);

    // Mode transitions and configuration capture on write cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg  <= CFG_RESET;
            mode <= MODE_ARRAY;
        end else if (wr_stb) begin
            if (mode == MODE_CFGSET) begin
                mode <= MODE_ARRAY;
                if (cmd == CMD_CFG_CONFIRM) begin
                    cfg <= cfg_in;
                end
            end else begin
                case (cmd)
                    CMD_CFG_SETUP:  mode <= MODE_CFGSET;
                    CMD_READ_ID:    mode <= MODE_IDENT;
                    CMD_READ_ARRAY: mode <= MODE_ARRAY;
                    default:        mode <= mode;
                endcase
            end
        end
    end

endmodule

// File: rtl/flash_burst_seq.sv
// Burst sequencer: counts the first-access latency, paces words by the hold
// length, generates the wrap or linear address order and raises WAIT.
// Assumes start and stop are never high together (start needs ce_n low).
module flash_burst_seq
    import flash_rd_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [2:0]       lat_code,
    input  logic             hold2,
    input  logic             wlead,
    input  logic             nowrap,
    input  logic [2:0]       bl_code,
    output logic             valid,
    output logic             wait_act,
    output logic [15:0]      word
);

    localparam int CW = 3;

    logic             busy;
    logic [CW-1:0]    cnt;
    logic             phase;
    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] widx;
    logic [CW-1:0]    lat;
    logic [CW-1:0]    lead;
    logic [IDX_W-1:0] mask;
    logic             wrap_on;
    logic [IDX_W-1:0] offs;
    logic [IDX_W-1:0] cur;

    // Latency decode: reserved codes fall back to the longest latency.
    always_comb begin
        lat = (lat_code >= 3'd2 && lat_code <= 3'd5) ? lat_code : 3'd5;
    end

    // Early WAIT release amount: one word-hold period when enabled.
    always_comb begin
        lead = wlead ? (hold2 ? 3'd2 : 3'd1) : 3'd0;
    end

    // Burst length decode into an address mask and wrap enable.
    always_comb begin
        mask    = '0;
        wrap_on = 1'b0;
        case (bl_code)
            3'd1: begin mask = IDX_W'(3);  wrap_on = !nowrap; end
            3'd2: begin mask = IDX_W'(7);  wrap_on = !nowrap; end
            3'd3: begin mask = IDX_W'(15); wrap_on = !nowrap; end
            default: begin mask = '0; wrap_on = 1'b0; end
        endcase
    end

    // Latency counter, hold phase and word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            phase <= 1'b0;
            widx  <= '0;
            base  <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= '0;
            phase <= 1'b0;
            widx  <= '0;
            base  <= start_idx;
        end else if (stop) begin
            busy  <= 1'b0;
        end else if (busy) begin
            if (cnt != lat) begin
                cnt <= cnt + 1'b1;
            end else if (!hold2 || phase) begin
                widx  <= widx + 1'b1;
                phase <= 1'b0;
            end else begin
                phase <= 1'b1;
            end
        end
    end

    // Address order and outputs.
    always_comb begin
        offs     = base + widx;
        cur      = wrap_on ? ((base & ~mask) | (offs & mask)) : offs;
        valid    = busy && (cnt == lat);
        wait_act = busy && ({1'b0, cnt} + {1'b0, lead} < {1'b0, lat});
        word     = valid ? array_word(16'(cur)) : 16'h0000;
    end

endmodule

// File: rtl/flash_out_stage.sv
// Output edge selector: passes burst outputs straight through for rising-
// edge operation, or presents a copy taken on the falling clock edge.
module flash_out_stage #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_edge,
    input  logic [DW-1:0] d_in,
    input  logic          v_in,
    input  logic          w_in,
    output logic [DW-1:0] d_out,
    output logic          v_out,
    output logic          w_out
);

    logic [DW-1:0] d_neg;
    logic          v_neg;
    logic          w_neg;

    // Falling-edge copy of the sequencer outputs.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            d_neg <= '0;
            v_neg <= 1'b0;
            w_neg <= 1'b0;
        end else begin
            d_neg <= d_in;
            v_neg <= v_in;
            w_neg <= w_in;
        end
    end

    // Edge selection.
    always_comb begin
        d_out = rise_edge ? d_in : d_neg;
        v_out = rise_edge ? v_in : v_neg;
        w_out = rise_edge ? w_in : w_neg;
    end

endmodule

// File: rtl/flash_burst_rd.sv
// Top: burst-read flash interface. Decodes bus strobes, holds the read
// configuration, and selects between asynchronous, identifier and burst
// read data. Assumes the bus is idle (ce_n high) around write cycles.
module flash_burst_rd
    import flash_rd_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        adv_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [15:0] addr,
    input  logic [7:0]  cmd,
    output logic [15:0] rdata,
    output logic        dvalid,
    output logic        wait_o
);

    logic        wr_stb;
    logic        burst_go;
    logic [15:0] cfg;
    rd_mode_e    mode;
    logic        seq_valid;
    logic        seq_wait;
    logic [15:0] seq_word;
    logic [15:0] st_word;
    logic        st_valid;
    logic        st_wait;
    logic        async_sel;
    logic [15:0] async_word;

    // Strobe decode for writes and burst starts.
    always_comb begin
        wr_stb   = !ce_n && !we_n;
        burst_go = !ce_n && !adv_n && we_n && (mode == MODE_ARRAY) && !cfg[CB_ASYNC];
    end

    flash_cmd_ctrl u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .cmd    (cmd),
        .cfg_in (addr),
        .cfg    (cfg),
        .mode   (mode)
    );

    flash_burst_seq #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (burst_go),
        .stop      (ce_n),
        .start_idx (addr[IDX_W-1:0]),
        .lat_code  (cfg[CB_LAT_HI:CB_LAT_LO]),
        .hold2     (cfg[CB_HOLD2]),
        .wlead     (cfg[CB_WLEAD]),
        .nowrap    (cfg[CB_NOWRAP]),
        .bl_code   (cfg[CB_BL_HI:CB_BL_LO]),
        .valid     (seq_valid),
        .wait_act  (seq_wait),
        .word      (seq_word)
    );

    flash_out_stage #(.DW(16)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_edge (cfg[CB_RISE]),
        .d_in      (seq_word),
        .v_in      (seq_valid),
        .w_in      (seq_wait),
        .d_out     (st_word),
        .v_out     (st_valid),
        .w_out     (st_wait)
    );

    // Untimed read path for array (async mode) and identifier reads.
    always_comb begin
        async_sel  = (mode != MODE_ARRAY) || cfg[CB_ASYNC];
        if (mode == MODE_IDENT) begin
            async_word = (addr[7:0] == ID_CFG_OFFSET) ? cfg : 16'h0000;
        end else begin
            async_word = array_word(16'(addr[IDX_W-1:0]));
        end
    end

    // Output selection and WAIT polarity.
    always_comb begin
        if (async_sel) begin
            rdata = (!ce_n && !oe_n) ? async_word : 16'h0000;
        end else begin
            rdata = st_word;
        end
        dvalid = st_valid;
        wait_o = st_wait ? cfg[CB_WPOL] : !cfg[CB_WPOL];
    end

endmodule

// File: rtl/flash_burst_rd_chk.sv
// Checker: temporal properties of the burst-read flash interface, attached
// to every instance of the top module through the bind below.
module flash_burst_rd_chk
    import flash_rd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        ce_n,
    input logic        wr_stb,
    input logic [7:0]  cmd,
    input logic [15:0] addr,
    input logic [15:0] cfg,
    input rd_mode_e    mode,
    input logic        seq_valid,
    input logic        seq_wait,
    input logic        dvalid,
    input logic        wait_o
);

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && mode == MODE_CFGSET && cmd == CMD_CFG_CONFIRM) |=> (cfg == $past(addr)));

    // R2
    cfg_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && mode == MODE_CFGSET) |=> (mode == MODE_ARRAY));

    // R3
    cfg_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && mode == MODE_CFGSET && cmd != CMD_CFG_CONFIRM) |=> $stable(cfg));

    // R3
    cfg_only_on_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> $past(wr_stb && mode == MODE_CFGSET && cmd == CMD_CFG_CONFIRM));

    // R11
    burst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!seq_valid && !seq_wait));

    // R12
    wait_data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dvalid && (wait_o == cfg[CB_WPOL])));

endmodule

bind flash_burst_rd flash_burst_rd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .wr_stb    (wr_stb),
    .cmd       (cmd),
    .addr      (addr),
    .cfg       (cfg),
    .mode      (mode),
    .seq_valid (seq_valid),
    .seq_wait  (seq_wait),
    .dvalid    (dvalid),
    .wait_o    (wait_o)
);

// File: tb/tb_flash_burst_rd.sv
// Bench: directed corner cases plus seeded random burst configurations,
// checked against expected values computed from the requirements.
module tb_flash_burst_rd;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        adv_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  cmd = '0;
    logic [15:0] rdata;
    logic        dvalid;
    logic        wait_o;

    int total = 0;
    int fails = 0;

    flash_burst_rd dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .adv_n  (adv_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .addr   (addr),
        .cmd    (cmd),
        .rdata  (rdata),
        .dvalid (dvalid),
        .wait_o (wait_o)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [15:0] word_of(input logic [7:0] i);
        return {i ^ 8'hC3, i};
    endfunction

    function automatic logic [7:0] burst_idx(input logic [7:0] b, input int w,
                                             input int bl, input logic wr);
        logic [7:0] o;
        o = b + 8'(w);
        if (wr) return (b & ~8'(bl - 1)) | (o & 8'(bl - 1));
        return o;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] c, input logic [15:0] a);
        @(posedge clk); #2;
        ce_n = 1'b0; we_n = 1'b0; cmd = c; addr = a;
        @(posedge clk); #2;
        ce_n = 1'b1; we_n = 1'b1; cmd = 8'h00;
    endtask

    task automatic async_read(input logic [15:0] a, output logic [15:0] d);
        @(posedge clk); #2;
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        #4 d = rdata;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic set_cfg(input logic [15:0] v);
        bus_write(8'h60, v);
        bus_write(8'h03, v);
    endtask

    task automatic id_read(input logic [7:0] off, output logic [15:0] d);
        bus_write(8'h90, 16'h0000);
        async_read({8'h00, off}, d);
        bus_write(8'hFF, 16'h0000);
    endtask

    // Loads v, runs one burst at base and checks every clock of it.
    task automatic run_burst(input logic [15:0] v, input logic [7:0] base);
        int lat, hold, lead, bl, nwin;
        logic wp, rise, wrap;
        lat  = (v[13:11] >= 3'd2 && v[13:11] <= 3'd5) ? int'(v[13:11]) : 5;
        hold = v[9] ? 2 : 1;
        lead = v[8] ? hold : 0;
        wp   = v[10];
        rise = v[6];
        case (v[2:0])
            3'd1: bl = 4;
            3'd2: bl = 8;
            3'd3: bl = 16;
            default: bl = 0;
        endcase
        wrap = !v[3] && (bl != 0);
        nwin = (bl != 0) ? lat + hold * (bl + 3) : lat + hold * 12;
        set_cfg(v);
        @(posedge clk); #2;
        ce_n = 1'b0; adv_n = 1'b0; addr = {8'h00, base};
        @(posedge clk); #2;
        adv_n = 1'b1;
        for (int j = 0; j < nwin; j++) begin
            logic ev, ew;
            logic [15:0] ed;
            if (j > 0) begin @(posedge clk); #2; end
            #1;
            if (j == lat) chk("R10 output edge", 32'(dvalid), 32'(rise));
            #5;
            ev = (j >= lat);
            ew = (j < lat - lead) ? wp : ~wp;
            ed = ev ? word_of(burst_idx(base, (j - lat) / hold, bl, wrap)) : 16'h0000;
            chk("R6 latency / R7 hold", 32'(dvalid), 32'(ev));
            chk("R8 wait", 32'(wait_o), 32'(ew));
            chk("R9 order", 32'(rdata), 32'(ed));
            chk("R12 exclusive", 32'(dvalid && (wait_o == wp)), 32'd0);
        end
        @(posedge clk); #2;
        ce_n = 1'b1; addr = '0;
        @(posedge clk); #8;
        chk("R11 stop", 32'({dvalid, wait_o}), 32'({1'b0, ~wp}));
    endtask

    initial begin
        #(CLK_P * 200000);
        total++; fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int seed;
        seed = int'($urandom(32'h5EED));
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #6;
        // R1 reset outputs
        chk("R1 dvalid", 32'(dvalid), 32'd0);
        chk("R1 wait", 32'(wait_o), 32'd0);
        id_read(8'h05, d);
        chk("R1 reset cfg", 32'(d), 32'hBFCF);
        // R5 asynchronous reads
        async_read(16'h0012, d);
        chk("R5 async word", 32'(d), 32'(word_of(8'h12)));
        async_read(16'hAB00, d);
        chk("R5 async low index", 32'(d), 32'(word_of(8'h00)));
        @(posedge clk); #2 ce_n = 1'b0; oe_n = 1'b1; addr = 16'h0033;
        #4 chk("R5 oe high gives zero", 32'(rdata), 32'd0);
        ce_n = 1'b1;
        bus_write(8'h20, 16'h0000);
        async_read(16'h0077, d);
        chk("R5 unknown code ignored", 32'(d), 32'(word_of(8'h77)));
        // R2 load and R4 readback
        set_cfg(16'h9ACB);
        async_read(16'h0041, d);
        chk("R2 back in array mode", 32'(d), 32'(word_of(8'h41)));
        id_read(8'h05, d);
        chk("R2 R4 cfg readback", 32'(d), 32'h9ACB);
        id_read(8'h03, d);
        chk("R4 other offset zero", 32'(d), 32'd0);
        async_read(16'h0005, d);
        chk("R4 FF restores array", 32'(d), 32'(word_of(8'h05)));
        // R3 aborted setup
        bus_write(8'h60, 16'h1234);
        bus_write(8'h55, 16'h1234);
        async_read(16'h0009, d);
        chk("R3 array after abort", 32'(d), 32'(word_of(8'h09)));
        id_read(8'h05, d);
        chk("R3 cfg unchanged", 32'(d), 32'h9ACB);
        // Directed bursts: shortest latency, wrap 4, rising edge
        run_burst(16'h10C1, 8'h0E);
        // Falling edge, two-clock hold with early WAIT: WAIT never active
        run_burst(16'h1781, 8'hFD);
        // Reserved latency code, active-low WAIT, no-wrap 16
        run_burst(16'h38CB, 8'h3C);
        // Random configurations
        for (int k = 0; k < 24; k++) begin
            logic [2:0] lc, blc;
            logic [15:0] v;
            int r;
            r = int'($urandom % 10);
            lc = (r < 8) ? 3'(2 + (r % 4)) : ((r == 8) ? 3'd1 : 3'd7);
            r = int'($urandom % 4);
            blc = (r == 3) ? 3'd7 : 3'(r + 1);
            v = {1'b0, 1'b0, lc, 1'($urandom), 1'($urandom), 1'($urandom),
                 1'b1, 1'($urandom), 2'b00, 1'($urandom), blc};
            run_burst(v, 8'($urandom));
            id_read(8'h05, d);
            chk("R4 random readback", 32'(d), 32'(v));
        end
        // Back to asynchronous mode
        set_cfg(16'hBFCF);
        async_read(16'h00E4, d);
        chk("R5 async restored", 32'(d), 32'(word_of(8'hE4)));
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule